// File: doc/BRIEF.md
# Gated-Entry Serial-In Parallel-Out Shift Register

This block is a chain of eight-stage shift registers that turns a serial bit stream into a wide parallel word. The bit taken in on each rising clock edge is the logical AND of two data inputs, so either input can act as a gate that forces zeros into the chain while the other carries the data. Every stage is visible on a parallel output bus. The last stage is also brought out alone so that a further instance on the same clock can extend the chain.

The number of eight-stage sections is set by a parameter, so the total length is always a multiple of eight. An active-low clear empties every stage at once without waiting for a clock edge. It holds the chain at zero for as long as it stays low. The first rising edge after the clear is released shifts as usual.

Top module: `sipo_chain`

## Requirements
- R1: The register has 8*NUM_DEV stages, presented on `q`, where `q[0]` is the first stage and `q[8*NUM_DEV-1]` is the last. After 8*NUM_DEV shifts with both data inputs high, every bit of `q` is 1.
- R2: The bit entering `q[0]` on a rising edge is `din_a & din_b`. A 1 enters only when both inputs are high; the input pairs 0/0, 0/1 and 1/0 all enter a 0.
- R3: On each rising edge with `clr_n` high, every stage `q[i]` with i>0 takes the value `q[i-1]` had before that edge.
- R4: When `clr_n` goes low, all of `q` becomes 0 at once, without a clock edge.
- R5: While `clr_n` stays low, `q` stays all zero whatever `clk`, `din_a` and `din_b` do.
- R6: The first rising edge after `clr_n` returns high performs a normal shift; no recovery cycle is inserted.
- R7: Sections are chained: on each shift, stage 8k (k>=1) takes the previous value of stage 8k-1. `cas_out` always equals the last stage, so it can drive the data input of a further instance on the same clock.
- R8: The data inputs are sampled only at the rising edge. A change of `din_a` or `din_b` between edges leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain moves on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| din_a | input | 1 | Serial data input, ANDed with `din_b` |
| din_b | input | 1 | Serial data input, ANDed with `din_a` |
| q | output | 8*NUM_DEV | Parallel stage outputs, bit 0 is the first stage |
| cas_out | output | 1 | Copy of the last stage, used for cascading |

## Verification
A shifted result is due one rising edge after the inputs are set. The bench therefore drives the data on the falling edge and compares `q` one nanosecond after the next rising edge. It checks this against a bench-side shift model fed with the AND of the two inputs. The clear has no clock latency. It is dropped between edges and checked before the next rising edge, which shows that it acts asynchronously. For the input-stability check, the data is changed just after an edge and `q` is checked again before the following edge. This shows that nothing moves until the edge after the change.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Width of one chained section
  localparam int STAGE_W = 8;

  function automatic int chain_len(input int sections);
    return sections * STAGE_W;
  endfunction
endpackage

// File: rtl/sipo_gate.sv
// Combines the two serial inputs into the bit that enters the first stage.
module sipo_gate (
  input  logic in_a,
  input  logic in_b,
  output logic entry
);
  assign entry = in_a & in_b;
endmodule

// File: rtl/sipo_octet.sv
// One eight-stage section with asynchronous active-low clear.
module sipo_octet #(
  parameter int W = sipo_pkg::STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= {q[W-2:0], ser_in};
  end

  assign ser_out = q[W-1];

  AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (q[W-1:1] == $past(q[W-2:0]))); // R3
  AST_STAGE_ENTRY: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (q[0] == $past(ser_in))); // R7
  AST_CLEAR_HOLD: assert property (@(posedge clk)
    !clr_n |-> (q == '0)); // R5
endmodule

// File: rtl/sipo_chain.sv
module sipo_chain #(
  parameter int NUM_DEV = 2
) (
  input  logic                                 clk,
  input  logic                                 clr_n,
  input  logic                                 din_a,
  input  logic                                 din_b,
  output logic [sipo_pkg::chain_len(NUM_DEV)-1:0] q,
  output logic                                 cas_out
);
  localparam int W   = sipo_pkg::STAGE_W;
  localparam int TOT = sipo_pkg::chain_len(NUM_DEV);

  logic [NUM_DEV:0] link;

  sipo_gate u_gate (
    .in_a  (din_a),
    .in_b  (din_b),
    .entry (link[0])
  );

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_sec
    sipo_octet #(.W(W)) u_sec (
      .clk     (clk),
      .clr_n   (clr_n),
      .ser_in  (link[k]),
      .q       (q[k*W +: W]),
      .ser_out (link[k+1])
    );
    if (k > 0) begin : g_join
      AST_SECTION_JOIN: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (q[k*W] == $past(q[k*W-1]))); // R7
    end
  end

  assign cas_out = link[NUM_DEV];

  AST_GATED_ENTRY: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (q[0] == $past(din_a & din_b))); // R2
  AST_CASCADE_TAP: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (cas_out == $past(q[TOT-2]))); // R7
endmodule

// File: tb/tb_sipo_chain.sv
`timescale 1ns/1ps
module tb_sipo_chain;
  localparam int NDEV = 2;
  localparam int TOT  = NDEV * 8;

  logic clk = 1'b0;
  logic clr_n, din_a, din_b;
  logic [TOT-1:0] q;
  logic cas_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [TOT-1:0] model;

  always #5 clk = ~clk;

  sipo_chain #(.NUM_DEV(NDEV)) dut (
    .clk(clk), .clr_n(clr_n), .din_a(din_a), .din_b(din_b),
    .q(q), .cas_out(cas_out)
  );

  // {din_a, din_b} per shift
  localparam logic [1:0] VEC [0:15] = '{
    2'b11, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b11, 2'b10,
    2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b11, 2'b11, 2'b01
  };

  task automatic chk(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic shift_in(input logic a, input logic b);
    @(negedge clk);
    din_a = a; din_b = b;
    @(posedge clk); #1;
    model = {model[TOT-2:0], a & b};
  endtask

  initial begin
    clr_n = 1'b1; din_a = 1'b0; din_b = 1'b0; model = '0;
    #1 clr_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R4 reset state", q, '0);
    chk("R7 reset cas_out", {{(TOT-1){1'b0}}, cas_out}, '0);

    // R2 R3 R6: vector walk, first edge after release shifts
    @(negedge clk); clr_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      shift_in(VEC[i][1], VEC[i][0]);
      chk($sformatf("R2 R3 vec%0d", i), q, model);
    end

    // R7 R1: walk a single one through the whole chain
    @(negedge clk); clr_n = 1'b0; model = '0;
    @(negedge clk); clr_n = 1'b1;
    shift_in(1'b1, 1'b1);
    for (int s = 1; s < TOT; s++) begin
      shift_in(1'b0, 1'b1);
      if (s == 8) chk("R7 section join", {{(TOT-1){1'b0}}, q[8]}, 1);
    end
    chk("R7 cas_out last stage", {{(TOT-1){1'b0}}, cas_out}, 1);
    chk("R1 one at last stage", q, {1'b1, {(TOT-1){1'b0}}});
    shift_in(1'b1, 1'b0);
    chk("R1 one leaves chain", q, '0);
    for (int s = 0; s < TOT; s++) shift_in(1'b1, 1'b1);
    chk("R1 all stages full", q, {TOT{1'b1}});

    // R4: clear between edges, no clock
    @(negedge clk); #2 clr_n = 1'b0; #1;
    chk("R4 async clear", q, '0);
    // R5: held while low
    din_a = 1'b1; din_b = 1'b1;
    for (int s = 0; s < 3; s++) begin
      @(posedge clk); #1;
      chk("R5 clear hold", q, '0);
    end
    // R6: first edge after release
    @(negedge clk); clr_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 first edge shifts", q, 1);
    // R8: mid-cycle data change has no effect until next edge
    din_a = 1'b0; #2;
    chk("R8 stable between edges", q, 1);
    @(posedge clk); #1;
    chk("R8 next edge takes zero", q, 2);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule